// File: doc/BRIEF.md
# Sum-Check Prover Round Engine

This block performs the prover's side of one sum-check layer over a prime field. Two multilinear tables, A and B, each with N = 2^LOG_N entries, are written into local registers through a load port. One evaluation unit sits beside each adjacent pair of entries. In every round, each unit computes the value of the product of the two linear interpolants at the points 0, 1 and 2. Three adder trees sum those values into the round polynomial. The result is offered to the verifier as a single transfer.

When the verifier has accepted the result, the engine takes a random challenge r. Each active unit folds its pair at r and writes the folded entry back into the table. The number of active units therefore halves every round. After LOG_N rounds a single folded pair is left. The engine raises `done` and presents that pair. All arithmetic is reduced modulo the parameter `PRIME`, whose default is 2^31 − 1.

Both streaming ports use valid/ready. The result is held stable until `res_ready` is seen with it. `ch_ready` stays low until the result of the current round has been consumed, so a challenge offered early waits with its `ch_valid` high. `ld_ready` is high only while the engine is idle. `start` and `done` are plain level pins. The modular multiply and add are combinational. The round sums are registered one cycle after the engine enters its summing state.

Top module: `sc_round_engine`

## Requirements
- R1: A load transfer (`ld_valid` and `ld_ready` both high) writes `ld_a mod PRIME` and `ld_b mod PRIME` into entry `ld_idx` of tables A and B. `ld_ready` is high only while idle, and is never high together with `res_valid` or `ch_ready`.
- R2: For round j with P active pairs, and for each k in {0,1,2}, `res_hk` equals the sum mod PRIME, over pairs i < P, of (A[2i] + k·(A[2i+1] − A[2i])) · (B[2i] + k·(B[2i+1] − B[2i])). Each sum is less than PRIME.
- R3: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and the three sums stay unchanged.
- R4: `ch_ready` is low while `res_valid` is high. It rises in the cycle after the result is consumed. A challenge presented early is not taken before then.
- R5: On a challenge transfer with value r, each active pair i is replaced by A[i] ← A[2i] + r·(A[2i+1] − A[2i]) mod PRIME, and B is folded in the same way. The next round then has half as many active pairs.
- R6: After LOG_N challenge transfers the engine returns to idle with `done` high, `fin_a` = A[0] and `fin_b` = B[0]. A new `start` clears `done`.
- R7: In every round, h0 + h1 mod PRIME equals the running claim. Before the first round the claim is Σ A[i]·B[i]. After each fold it is the same sum over the folded tables. After the last fold it equals `fin_a`·`fin_b` mod PRIME.
- R8: After reset the engine is idle: `ld_ready`=1, `res_valid`=0, `ch_ready`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Load entry valid |
| ld_ready | output | 1 | Engine idle, accepts loads |
| ld_idx | input | LOG_N | Table entry index |
| ld_a | input | 32 | Value for table A |
| ld_b | input | 32 | Value for table B |
| start | input | 1 | Begin the rounds (taken while idle) |
| res_valid | output | 1 | Round sums valid |
| res_ready | input | 1 | Verifier takes the round sums |
| res_h0 | output | 32 | Round sum at point 0 |
| res_h1 | output | 32 | Round sum at point 1 |
| res_h2 | output | 32 | Round sum at point 2 |
| ch_valid | input | 1 | Challenge valid |
| ch_ready | output | 1 | Engine accepts a challenge |
| ch_value | input | 32 | Challenge r (reduced mod PRIME) |
| done | output | 1 | All rounds complete |
| fin_a | output | 32 | Final folded A value |
| fin_b | output | 32 | Final folded B value |

## Verification
The hardest situation to bring about is a challenge that is already valid while the round result is still unconsumed. Reaching it takes control of the order of two separate handshakes. The stimulus raises `ch_valid`, carrying the intended value, before each round result appears. It then holds `res_ready` low for a chosen number of stall cycles, so that the hold-off and the stability of the sums are both observed. Only after that does it release `res_ready`.

Table vectors include entries at PRIME−1, an input above PRIME that must be reduced on load, and challenges of 0, 1 and PRIME−1. These push every subtraction through its wrap-around branch.

// File: rtl/sc_pkg.sv
package sc_pkg;
  parameter int unsigned SC_W = 32;

  typedef enum logic [1:0] {S_IDLE, S_SUM, S_RES, S_CHAL} sc_state_t;

  function automatic logic [SC_W-1:0] f_add(input logic [SC_W-1:0] a,
                                            input logic [SC_W-1:0] b,
                                            input logic [SC_W-1:0] p);
    logic [SC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, p}) s = s - {1'b0, p};
    return s[SC_W-1:0];
  endfunction

  function automatic logic [SC_W-1:0] f_sub(input logic [SC_W-1:0] a,
                                            input logic [SC_W-1:0] b,
                                            input logic [SC_W-1:0] p);
    if (a >= b) return a - b;
    return (p - b) + a;
  endfunction

  function automatic logic [SC_W-1:0] f_red(input logic [SC_W-1:0] a,
                                            input logic [SC_W-1:0] p);
    return a % p;
  endfunction

  function automatic logic [SC_W-1:0] f_mul(input logic [SC_W-1:0] a,
                                            input logic [SC_W-1:0] b,
                                            input logic [SC_W-1:0] p);
    logic [2*SC_W-1:0] m;
    logic [2*SC_W-1:0] q;
    m = {{SC_W{1'b0}}, a} * {{SC_W{1'b0}}, b};
    q = m % {{SC_W{1'b0}}, p};
    return q[SC_W-1:0];
  endfunction
endpackage

// File: rtl/sc_gate_unit.sv
module sc_gate_unit
  import sc_pkg::*;
#(
  parameter logic [SC_W-1:0] PRIME = 32'h7FFF_FFFF
) (
  input  logic [SC_W-1:0] a_lo,
  input  logic [SC_W-1:0] a_hi,
  input  logic [SC_W-1:0] b_lo,
  input  logic [SC_W-1:0] b_hi,
  input  logic [SC_W-1:0] r,
  output logic [SC_W-1:0] c0,
  output logic [SC_W-1:0] c1,
  output logic [SC_W-1:0] c2,
  output logic [SC_W-1:0] fold_a,
  output logic [SC_W-1:0] fold_b
);
  logic [SC_W-1:0] da, db, a_at2, b_at2;

  always_comb begin
    da     = f_sub(a_hi, a_lo, PRIME);
    db     = f_sub(b_hi, b_lo, PRIME);
    a_at2  = f_add(a_hi, da, PRIME);
    b_at2  = f_add(b_hi, db, PRIME);
    c0     = f_mul(a_lo, b_lo, PRIME);
    c1     = f_mul(a_hi, b_hi, PRIME);
    c2     = f_mul(a_at2, b_at2, PRIME);
    fold_a = f_add(a_lo, f_mul(r, da, PRIME), PRIME);
    fold_b = f_add(b_lo, f_mul(r, db, PRIME), PRIME);
  end
endmodule

// File: rtl/sc_addtree.sv
module sc_addtree
  import sc_pkg::*;
#(
  parameter int unsigned     LEAVES = 4,
  parameter logic [SC_W-1:0] PRIME  = 32'h7FFF_FFFF
) (
  input  logic [SC_W-1:0] leaf [LEAVES],
  output logic [SC_W-1:0] sum
);
  localparam int unsigned NODES = 2 * LEAVES - 1;

  logic [SC_W-1:0] node [NODES];

  genvar i;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      assign node[LEAVES-1+i] = leaf[i];
    end
    for (i = 0; i < LEAVES - 1; i++) begin : g_inner
      assign node[i] = f_add(node[2*i+1], node[2*i+2], PRIME);
    end
  endgenerate

  assign sum = node[0];
endmodule

// File: rtl/sc_round_engine.sv
module sc_round_engine
  import sc_pkg::*;
#(
  parameter logic [SC_W-1:0] PRIME = 32'h7FFF_FFFF,
  parameter int unsigned     LOG_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [LOG_N-1:0] ld_idx,
  input  logic [SC_W-1:0]  ld_a,
  input  logic [SC_W-1:0]  ld_b,
  input  logic             start,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [SC_W-1:0]  res_h0,
  output logic [SC_W-1:0]  res_h1,
  output logic [SC_W-1:0]  res_h2,
  input  logic             ch_valid,
  output logic             ch_ready,
  input  logic [SC_W-1:0]  ch_value,
  output logic             done,
  output logic [SC_W-1:0]  fin_a,
  output logic [SC_W-1:0]  fin_b
);
  localparam int unsigned N = 1 << LOG_N;
  localparam int unsigned G = N / 2;

  sc_state_t       st_q;
  logic            done_q;
  logic [LOG_N-1:0] pairs_q;
  logic [SC_W-1:0] tab_a [N];
  logic [SC_W-1:0] tab_b [N];
  logic [SC_W-1:0] h0_q, h1_q, h2_q;

  logic [SC_W-1:0] r_red;
  logic [SC_W-1:0] c0 [G];
  logic [SC_W-1:0] c1 [G];
  logic [SC_W-1:0] c2 [G];
  logic [SC_W-1:0] m0 [G];
  logic [SC_W-1:0] m1 [G];
  logic [SC_W-1:0] m2 [G];
  logic [SC_W-1:0] fa [G];
  logic [SC_W-1:0] fb [G];
  logic [G-1:0]    active;
  logic [SC_W-1:0] t0, t1, t2;

  assign r_red = f_red(ch_value, PRIME);

  genvar gi;
  generate
    for (gi = 0; gi < G; gi++) begin : g_unit
      sc_gate_unit #(.PRIME(PRIME)) u_unit (
        .a_lo  (tab_a[2*gi]),
        .a_hi  (tab_a[2*gi+1]),
        .b_lo  (tab_b[2*gi]),
        .b_hi  (tab_b[2*gi+1]),
        .r     (r_red),
        .c0    (c0[gi]),
        .c1    (c1[gi]),
        .c2    (c2[gi]),
        .fold_a(fa[gi]),
        .fold_b(fb[gi])
      );
      assign active[gi] = (gi < int'(pairs_q));
      assign m0[gi] = active[gi] ? c0[gi] : '0;
      assign m1[gi] = active[gi] ? c1[gi] : '0;
      assign m2[gi] = active[gi] ? c2[gi] : '0;
    end
  endgenerate

  sc_addtree #(.LEAVES(G), .PRIME(PRIME)) u_tree0 (.leaf(m0), .sum(t0));
  sc_addtree #(.LEAVES(G), .PRIME(PRIME)) u_tree1 (.leaf(m1), .sum(t1));
  sc_addtree #(.LEAVES(G), .PRIME(PRIME)) u_tree2 (.leaf(m2), .sum(t2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      done_q  <= 1'b0;
      pairs_q <= '0;
      h0_q    <= '0;
      h1_q    <= '0;
      h2_q    <= '0;
      for (int i = 0; i < N; i++) begin
        tab_a[i] <= '0;
        tab_b[i] <= '0;
      end
    end else begin
      case (st_q)
        S_IDLE: begin
          if (ld_valid) begin
            tab_a[ld_idx] <= f_red(ld_a, PRIME);
            tab_b[ld_idx] <= f_red(ld_b, PRIME);
          end
          if (start) begin
            st_q    <= S_SUM;
            done_q  <= 1'b0;
            pairs_q <= LOG_N'(G);
          end
        end
        S_SUM: begin
          h0_q <= t0;
          h1_q <= t1;
          h2_q <= t2;
          st_q <= S_RES;
        end
        S_RES: begin
          if (res_ready) st_q <= S_CHAL;
        end
        S_CHAL: begin
          if (ch_valid) begin
            for (int i = 0; i < G; i++) begin
              if (active[i]) begin
                tab_a[i] <= fa[i];
                tab_b[i] <= fb[i];
              end
            end
            pairs_q <= pairs_q >> 1;
            if (pairs_q == LOG_N'(1)) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q <= S_SUM;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ld_ready  = (st_q == S_IDLE);
  assign res_valid = (st_q == S_RES);
  assign ch_ready  = (st_q == S_CHAL);
  assign res_h0    = h0_q;
  assign res_h1    = h1_q;
  assign res_h2    = h2_q;
  assign done      = done_q;
  assign fin_a     = tab_a[0];
  assign fin_b     = tab_b[0];
endmodule

// File: rtl/sc_round_engine_chk.sv
module sc_round_engine_chk
  import sc_pkg::*;
#(
  parameter logic [SC_W-1:0] PRIME = 32'h7FFF_FFFF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [SC_W-1:0] res_h0,
  input logic [SC_W-1:0] res_h1,
  input logic [SC_W-1:0] res_h2,
  input logic            ch_valid,
  input logic            ch_ready,
  input logic            done,
  input logic [SC_W-1:0] fin_a,
  input logic [SC_W-1:0] fin_b
);
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (!res_valid && !ch_ready)); // R1

  AST_SUMS_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_h0 < PRIME && res_h1 < PRIME && res_h2 < PRIME)); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_h0) && $stable(res_h1) && $stable(res_h2))); // R3

  AST_NO_EARLY_CHALLENGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !ch_ready); // R4

  AST_CHALLENGE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> ch_ready); // R4

  AST_FOLD_LEAVES_CHAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && ch_ready) |=> !ch_ready); // R5

  AST_DONE_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ld_ready && fin_a < PRIME && fin_b < PRIME)); // R6
endmodule

bind sc_round_engine sc_round_engine_chk #(.PRIME(PRIME)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_ready (ld_ready),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_h0   (res_h0),
  .res_h1   (res_h1),
  .res_h2   (res_h2),
  .ch_valid (ch_valid),
  .ch_ready (ch_ready),
  .done     (done),
  .fin_a    (fin_a),
  .fin_b    (fin_b)
);

// File: tb/sc_round_engine_bench.sv
module sc_round_engine_bench;
  localparam int          LOG_N = 3;
  localparam int          N     = 1 << LOG_N;
  localparam longint unsigned P = 64'd2147483647;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [LOG_N-1:0] ld_idx = '0;
  logic [31:0] ld_a = '0, ld_b = '0;
  logic        start = 1'b0;
  logic        res_valid, res_ready = 1'b0;
  logic [31:0] res_h0, res_h1, res_h2;
  logic        ch_valid = 1'b0, ch_ready;
  logic [31:0] ch_value = '0;
  logic        done;
  logic [31:0] fin_a, fin_b;

  int checks = 0;
  int failures = 0;

  logic [31:0]     va [N];
  logic [31:0]     vb [N];
  logic [31:0]     vch [LOG_N];
  longint unsigned ra [N];
  longint unsigned rb [N];
  longint unsigned seed = 64'd12345;

  always #10 clk = ~clk;

  sc_round_engine #(.PRIME(32'h7FFF_FFFF), .LOG_N(LOG_N)) u_sc_round_engine (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_idx(ld_idx), .ld_a(ld_a), .ld_b(ld_b),
    .start(start),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_h0(res_h0), .res_h1(res_h1), .res_h2(res_h2),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_value(ch_value),
    .done(done), .fin_a(fin_a), .fin_b(fin_b)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned msub(input longint unsigned a, input longint unsigned b);
    return (a + P - b) % P;
  endfunction

  function automatic longint unsigned interp(input longint unsigned lo, input longint unsigned hi,
                                             input longint unsigned k);
    return (lo + (k * msub(hi, lo)) % P) % P;
  endfunction

  function automatic longint unsigned next_rand();
    seed = (seed * 64'd6364136223846793005 + 64'd1442695040888963407);
    return seed >> 33;
  endfunction

  task automatic run_vector(input int stall);
    longint unsigned claim, eh [3];
    int pairs;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      check("R1 ld_ready idle", ld_ready, 1);
      ld_valid = 1'b1; ld_idx = LOG_N'(i); ld_a = va[i]; ld_b = vb[i];
      ra[i] = longint'(va[i]) % P;
      rb[i] = longint'(vb[i]) % P;
    end
    @(negedge clk);
    ld_valid = 1'b0;
    claim = 0;
    for (int i = 0; i < N; i++) claim = (claim + (ra[i] * rb[i]) % P) % P;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 done cleared by start", done, 0);
    for (int rd = 0; rd < LOG_N; rd++) begin
      pairs = N >> (rd + 1);
      ch_valid = 1'b1;
      ch_value = vch[rd];
      while (!res_valid) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        eh[k] = 0;
        for (int i = 0; i < pairs; i++)
          eh[k] = (eh[k] + (interp(ra[2*i], ra[2*i+1], longint'(k)) *
                            interp(rb[2*i], rb[2*i+1], longint'(k))) % P) % P;
      end
      check("R2 h0", res_h0, eh[0]);
      check("R2 h1", res_h1, eh[1]);
      check("R2 h2", res_h2, eh[2]);
      check("R7 h0+h1 equals claim", (longint'(res_h0) + longint'(res_h1)) % P, claim);
      check("R4 early challenge held off", ch_ready, 0);
      check("R1 no load while busy", ld_ready, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check("R3 result held valid", res_valid, 1);
        check("R3 result held stable", res_h2, eh[2]);
        check("R4 challenge still held off", ch_ready, 0);
      end
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      check("R4 challenge ready after result", ch_ready, 1);
      @(negedge clk);
      ch_valid = 1'b0;
      for (int i = 0; i < pairs; i++) begin
        ra[i] = interp(ra[2*i], ra[2*i+1], longint'(vch[rd]) % P);
        rb[i] = interp(rb[2*i], rb[2*i+1], longint'(vch[rd]) % P);
      end
      claim = 0;
      for (int i = 0; i < pairs; i++) claim = (claim + (ra[i] * rb[i]) % P) % P;
    end
    check("R6 done after last round", done, 1);
    check("R5 R6 fin_a", fin_a, ra[0]);
    check("R5 R6 fin_b", fin_b, rb[0]);
    check("R7 final claim", (longint'(fin_a) * longint'(fin_b)) % P, claim);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 ld_ready at reset", ld_ready, 1);
    check("R8 res_valid at reset", res_valid, 0);
    check("R8 ch_ready at reset", ch_ready, 0);
    check("R8 done at reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", ld_ready, 1);

    for (int i = 0; i < N; i++) begin
      va[i] = 32'(i + 1); vb[i] = 32'(2 * i + 3);
    end
    vch[0] = 32'd5; vch[1] = 32'd7; vch[2] = 32'd11;
    run_vector(0);

    for (int i = 0; i < N; i++) begin
      va[i] = 32'(P - 1); vb[i] = (i % 2 == 0) ? 32'd0 : 32'(P - 1);
    end
    va[0] = 32'hFFFF_FFFF;
    vch[0] = 32'(P - 1); vch[1] = 32'd0; vch[2] = 32'd1;
    run_vector(2);

    for (int v = 0; v < 8; v++) begin
      for (int i = 0; i < N; i++) begin
        va[i] = 32'(next_rand()); vb[i] = 32'(next_rand());
      end
      for (int r = 0; r < LOG_N; r++) vch[r] = 32'(next_rand());
      run_vector(v % 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule